// File: doc/BRIEF.md
# Step-Down Converter Fault Supervisor

This block is the protection supervisor of a step-down converter. It does not sense anything itself. Analog comparators report overcurrent, short-circuit, output voltage high or low, die temperature, enable level and supply power-on-reset as digital levels. The block double-registers these levels and then decides three things: when to latch the converter off, when to pull the power-good line down, and how to gate the high-side and low-side drive requests coming from the PWM modulator.

Each fault has its own set and clear rule:

- **Overcurrent** is qualified per PWM pulse over a timed window.
- **Short-circuit** trips after a short hold filter.
- **Output over-voltage** latches until supply reset. While it is latched, the low-side switch follows a hysteretic output-voltage rule.
- **Output under-voltage** latches until enable drops or supply reset.
- **Over-temperature** only pauses switching until the die has cooled.

The window lengths are given in nanoseconds and turned into cycle counts from the clock-period parameter.

Top module: `buck_fault_supervisor`

## Requirements
- R1: After reset no fault bit is set. Every comparator, enable and power-on-reset input passes through SYNC_STAGES (2) flops, so a raw level driven before clock edge A first changes a fault bit at edge A+2. With no fault bit set, hs_gate_o equals hs_req_i and ls_gate_o equals ls_req_i in the same cycle.
- R2: An overcurrent timer starts on a pwm_strobe_i cycle that sees the synchronized overcurrent flag high. Later strobes that see it high leave the timer alone. fault_o[0] sets OC_CYCLES = OC_WINDOW_NS/CLK_PERIOD_NS edges after the starting strobe edge. A strobe that sees the flag low stops and clears the timer.
- R3: If the raw short-circuit input stays high, fault_o[1] sets on the SC_CYCLES-th edge, counting the first edge that samples the input (SC_CYCLES = SC_WINDOW_NS/CLK_PERIOD_NS). A pulse that drops before then sets nothing.
- R4: The over-voltage-rising flag sets fault_o[2] and pg_pulldown_o and holds hs_gate_o low. Enable low does not clear it; only power-on-reset does.
- R5: While fault_o[2] is set, ls_gate_o ignores ls_req_i. It goes high once the rising over-voltage flag is seen and low once the falling over-voltage flag is seen low.
- R6: The under-voltage flag sets fault_o[3] and pg_pulldown_o. The bit stays set after the flag drops and clears when enable is low or power-on-reset is high.
- R7: The over-temperature flag sets fault_o[4] and forces both gates low without touching pg_pulldown_o. The bit clears when the cool flag is high while the over-temperature flag is low, or when enable is low. The over-temperature flag wins over the cool flag.
- R8: An under-voltage flag arriving while fault_o[4] is set latches fault_o[3] as usual, and that bit outlives the over-temperature state.
- R9: fault_o is one bit per fault: bit 0 overcurrent, bit 1 short-circuit, bit 2 over-voltage, bit 3 under-voltage, bit 4 over-temperature. Any set bit forces hs_gate_o low, and ls_gate_o low unless bit 2 is set, in the same cycle the bit appears.
- R10: The overcurrent and short-circuit bits assert pg_pulldown_o and clear on enable low or power-on-reset.
- R11: Power-on-reset high clears every fault bit and the low-side over-voltage state. A clear condition overrides any set condition for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_i | input | 1 | Supply power-on-reset active (raw) |
| en_i | input | 1 | Enable level (raw) |
| oc_i | input | 1 | Sense current above overcurrent threshold (raw) |
| sc_i | input | 1 | Sense current above twice the threshold (raw) |
| ov_hi_i | input | 1 | Output above rising over-voltage threshold (raw) |
| ov_lo_i | input | 1 | Output above falling over-voltage threshold (raw) |
| uv_i | input | 1 | Output below under-voltage threshold (raw) |
| ot_i | input | 1 | Die above rising temperature threshold (raw) |
| cool_i | input | 1 | Die below hysteresis temperature (raw) |
| pwm_strobe_i | input | 1 | One-cycle strobe per PWM pulse |
| hs_req_i | input | 1 | High-side gate request from modulator |
| ls_req_i | input | 1 | Low-side gate request from modulator |
| hs_gate_o | output | 1 | Gated high-side command |
| ls_gate_o | output | 1 | Gated low-side command |
| pg_pulldown_o | output | 1 | Power-good pulldown enable |
| fault_o | output | 5 | One bit per fault |

## Verification
Some rules are checked on every cycle by the assertions:

- the clear rules: enable cannot clear over-voltage, enable low empties under-voltage, and power-on-reset empties everything;
- the low-side follow rule under over-voltage;
- gating by non-over-voltage faults;
- power-good staying quiet for a temperature-only fault;
- the overcurrent restart on a clean strobe;
- the short-circuit trip only after a held flag.

Only the bench scenarios can show the exact trip instants of the overcurrent window and the short-circuit filter, the two-flop input latency, and the cross-fault orderings such as under-voltage latching during over-temperature.

// File: rtl/bfs_pkg.sv
// Package: shared fault bit positions and the comparator flag bundle.
// Assumes: fault bit positions are part of the external status contract.
package bfs_pkg;
    localparam int FAULT_W = 5;
    localparam int F_OC    = 0;
    localparam int F_SC    = 1;
    localparam int F_OV    = 2;
    localparam int F_UV    = 3;
    localparam int F_OT    = 4;

    typedef struct packed {
        logic por;
        logic en;
        logic oc;
        logic sc;
        logic ov_hi;
        logic ov_lo;
        logic uv;
        logic ot;
        logic cool;
    } cmp_flags_t;

    localparam int CMP_W = $bits(cmp_flags_t);
endpackage

// File: rtl/bfs_sync.sv
// Module: multi-stage level synchronizer for a vector of comparator flags.
// Assumes: inputs are slow levels; bits are synchronized independently.
module bfs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the flag vector one stage per clock.
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bfs_oc_window.sv
// Module: overcurrent qualification window. A strobe seeing the flag high
// starts a timer; a strobe seeing it low stops and clears it. trip_o is high
// once the timer has run WINDOW_CYCLES-1 cycles past its start.
// Assumes: over_i is already synchronized; strobe_i is one cycle per pulse.
module bfs_oc_window #(
    parameter int WINDOW_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic strobe_i,
    input  logic over_i,
    output logic trip_o
);
    localparam int CW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    logic          running_q;
    logic [CW-1:0] cnt_q;

    // Start, restart or advance the window timer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (strobe_i && !over_i) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (strobe_i && over_i && !running_q) begin
            running_q <= 1'b1;
            cnt_q     <= '0;
        end else if (running_q && cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign trip_o = running_q && (cnt_q == LAST);

    // R2: a clean pulse leaves no pending trip on the next cycle.
    assert_oc_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !over_i) |=> !trip_o);
    // R2: a fresh window always begins from a zero count.
    assert_oc_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_q) |-> (cnt_q == '0));
endmodule

// File: rtl/bfs_sc_filter.sv
// Module: short-circuit hold filter. trip_o is high when the flag has been
// high for HOLD_CYCLES consecutive cycles including the current one.
// Assumes: flag_i is already synchronized; HOLD_CYCLES >= 2.
module bfs_sc_filter #(
    parameter int HOLD_CYCLES = 998
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic flag_i,
    output logic trip_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive cycles with the flag high, saturating at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !flag_i) cnt_q <= '0;
        else if (cnt_q != LAST)         cnt_q <= cnt_q + CW'(1);
    end

    assign trip_o = flag_i && (cnt_q == LAST);

    // R3: a trip requires the flag to have been high one cycle earlier too.
    assert_sc_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> $past(flag_i));
endmodule

// File: rtl/buck_fault_supervisor.sv
// Module: protection supervisor for a step-down converter. Synchronizes the
// comparator flags, keeps one latch per fault with its own clear rule,
// tracks the low-side over-voltage hysteresis state, and gates the PWM
// gate requests. Assumes: windows are multiples of the clock period and
// SC_WINDOW_NS/CLK_PERIOD_NS exceeds SYNC_STAGES+1.
module buck_fault_supervisor #(
    parameter int CLK_PERIOD_NS = 10,
    parameter int OC_WINDOW_NS  = 20000,
    parameter int SC_WINDOW_NS  = 10000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       por_i,
    input  logic                       en_i,
    input  logic                       oc_i,
    input  logic                       sc_i,
    input  logic                       ov_hi_i,
    input  logic                       ov_lo_i,
    input  logic                       uv_i,
    input  logic                       ot_i,
    input  logic                       cool_i,
    input  logic                       pwm_strobe_i,
    input  logic                       hs_req_i,
    input  logic                       ls_req_i,
    output logic                       hs_gate_o,
    output logic                       ls_gate_o,
    output logic                       pg_pulldown_o,
    output logic [bfs_pkg::FAULT_W-1:0] fault_o
);
    import bfs_pkg::*;

    localparam int OC_CYCLES = OC_WINDOW_NS / CLK_PERIOD_NS;
    localparam int SC_CYCLES = SC_WINDOW_NS / CLK_PERIOD_NS;
    localparam int SC_HOLD   = SC_CYCLES - SYNC_STAGES;

    cmp_flags_t         raw_flags;
    cmp_flags_t         syn;
    logic [CMP_W-1:0]   syn_vec;
    logic               soft_clr;
    logic               hard_clr;
    logic               oc_trip;
    logic               sc_trip;
    logic [FAULT_W-1:0] fault_q;
    logic [FAULT_W-1:0] fault_d;
    logic               ov_ls_q;
    logic               any_fault;

    assign raw_flags = {por_i, en_i, oc_i, sc_i, ov_hi_i, ov_lo_i, uv_i, ot_i, cool_i};

    bfs_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_flags),
        .q_o   (syn_vec)
    );
    assign syn = cmp_flags_t'(syn_vec);

    assign hard_clr = syn.por;
    assign soft_clr = syn.por || !syn.en;

    bfs_oc_window #(.WINDOW_CYCLES(OC_CYCLES)) u_oc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (soft_clr),
        .strobe_i (pwm_strobe_i),
        .over_i   (syn.oc),
        .trip_o   (oc_trip)
    );

    bfs_sc_filter #(.HOLD_CYCLES(SC_HOLD)) u_sc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (soft_clr),
        .flag_i (syn.sc),
        .trip_o (sc_trip)
    );

    // Next state of each fault latch under its own set and clear rule.
    always_comb begin
        fault_d = fault_q;
        if (syn.ov_hi) fault_d[F_OV] = 1'b1;
        if (oc_trip)   fault_d[F_OC] = 1'b1;
        if (sc_trip)   fault_d[F_SC] = 1'b1;
        if (syn.uv)    fault_d[F_UV] = 1'b1;
        if (syn.ot)        fault_d[F_OT] = 1'b1;
        else if (syn.cool) fault_d[F_OT] = 1'b0;
        if (soft_clr) begin
            fault_d[F_OC] = 1'b0;
            fault_d[F_SC] = 1'b0;
            fault_d[F_UV] = 1'b0;
            fault_d[F_OT] = 1'b0;
        end
        if (hard_clr) fault_d = '0;
    end

    // Register the fault latches.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= fault_d;
    end

    // Low-side hysteresis state: on above rising level, off below falling level.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_clr) ov_ls_q <= 1'b0;
        else if (syn.ov_hi)     ov_ls_q <= 1'b1;
        else if (!syn.ov_lo)    ov_ls_q <= 1'b0;
    end

    // Gate the modulator requests with the current fault state.
    always_comb begin
        any_fault = |fault_q;
        hs_gate_o = hs_req_i && !any_fault;
        if (fault_q[F_OV]) ls_gate_o = ov_ls_q;
        else               ls_gate_o = ls_req_i && !any_fault;
    end

    assign pg_pulldown_o = fault_q[F_OC] | fault_q[F_SC] | fault_q[F_OV] | fault_q[F_UV];
    assign fault_o       = fault_q;

    // R4: enable alone never clears the over-voltage latch.
    assert_ov_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q[F_OV] && !syn.por) |=> fault_q[F_OV]);
    // R5: after the rising flag, a latched over-voltage drives low side on.
    assert_ov_ls_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q[F_OV] && $past(syn.ov_hi) && !$past(syn.por)) |-> ls_gate_o);
    // R6: enable low empties the under-voltage latch on the next cycle.
    assert_uv_en_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !syn.en |=> !fault_q[F_UV]);
    // R7: a temperature-only fault leaves power-good released.
    assert_ot_no_pg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q[F_OT] && $countones(fault_q) == 1) |-> !pg_pulldown_o);
    // R9: any fault other than over-voltage silences both gates.
    assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fault_q) && !fault_q[F_OV]) |-> (!hs_gate_o && !ls_gate_o));
    // R11: power-on-reset empties every latch and the hysteresis state.
    assert_por_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        syn.por |=> (fault_q == '0 && !ov_ls_q));
endmodule

// File: tb/tb_buck_fault_supervisor.sv
module tb_buck_fault_supervisor;
    localparam int CLK_NS = 10;
    localparam int OC_NS  = 2000;
    localparam int SC_NS  = 1000;
    localparam int OC_CYC = OC_NS / CLK_NS;
    localparam int SC_CYC = SC_NS / CLK_NS;

    // Vector: [10]ot [9]cool [8]hs_req [7]ls_req [6]exp_hs [5]exp_ls [4:0]exp_fault
    localparam logic [10:0] VEC [7] = '{
        11'b0_1_1_0_1_0_00000,
        11'b0_1_0_1_0_1_00000,
        11'b1_0_1_0_0_0_10000,
        11'b0_0_0_1_0_0_10000,
        11'b1_1_1_0_0_0_10000,
        11'b0_1_1_0_1_0_00000,
        11'b0_1_0_1_0_1_00000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_i = 1'b0, en_i = 1'b1, oc_i = 1'b0, sc_i = 1'b0;
    logic ov_hi_i = 1'b0, ov_lo_i = 1'b0, uv_i = 1'b0, ot_i = 1'b0, cool_i = 1'b1;
    logic pwm_strobe_i = 1'b0, hs_req_i = 1'b0, ls_req_i = 1'b0;
    logic hs_gate_o, ls_gate_o, pg_pulldown_o;
    logic [4:0] fault_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    buck_fault_supervisor #(
        .CLK_PERIOD_NS(CLK_NS), .OC_WINDOW_NS(OC_NS), .SC_WINDOW_NS(SC_NS), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .en_i(en_i), .oc_i(oc_i), .sc_i(sc_i),
        .ov_hi_i(ov_hi_i), .ov_lo_i(ov_lo_i), .uv_i(uv_i), .ot_i(ot_i), .cool_i(cool_i),
        .pwm_strobe_i(pwm_strobe_i), .hs_req_i(hs_req_i), .ls_req_i(ls_req_i),
        .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o), .pg_pulldown_o(pg_pulldown_o),
        .fault_o(fault_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act < exp - 1 || act > exp + 1) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Advance n rising edges; return at the following falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_pulse();
        pwm_strobe_i = 1'b1;
        tick(1);
        pwm_strobe_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int n;
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1", "fault after reset", fault_o, 0);
        check("R1", "pg after reset", pg_pulldown_o, 0);

        // Table walk: pass-through and over-temperature (R1, R7).
        for (int i = 0; i < 7; i++) begin
            ot_i = VEC[i][10]; cool_i = VEC[i][9];
            hs_req_i = VEC[i][8]; ls_req_i = VEC[i][7];
            tick(3);
            check("R7", $sformatf("vec%0d hs", i), hs_gate_o, VEC[i][6]);
            check("R7", $sformatf("vec%0d ls", i), ls_gate_o, VEC[i][5]);
            check("R7", $sformatf("vec%0d fault", i), fault_o, VEC[i][4:0]);
            check("R7", $sformatf("vec%0d pg", i), pg_pulldown_o, 0);
        end

        // Under-voltage latch, sync latency and gating (R1, R6, R9).
        hs_req_i = 1'b1; ls_req_i = 1'b0;
        uv_i = 1'b1;
        tick(2);
        check("R1", "uv not yet visible after 2 edges", fault_o, 0);
        tick(1);
        check("R6", "uv latched", fault_o, 5'b01000);
        check("R6", "uv pg", pg_pulldown_o, 1);
        check("R9", "hs off on uv", hs_gate_o, 0);
        uv_i = 1'b0;
        tick(3);
        check("R6", "uv stays latched", fault_o, 5'b01000);
        en_i = 1'b0;
        tick(3);
        check("R6", "uv cleared by enable", fault_o, 0);
        check("R6", "pg released", pg_pulldown_o, 0);
        en_i = 1'b1;
        tick(3);
        check("R1", "hs pass-through", hs_gate_o, 1);

        // Over-temperature then under-voltage (R7, R8).
        ot_i = 1'b1;
        tick(3);
        check("R7", "ot set", fault_o, 5'b10000);
        en_i = 1'b0;
        tick(3);
        check("R7", "ot cleared by enable", fault_o, 0);
        en_i = 1'b1;
        tick(3);
        check("R7", "ot back with enable", fault_o, 5'b10000);
        uv_i = 1'b1;
        tick(3);
        check("R8", "uv during ot", fault_o, 5'b11000);
        check("R8", "pg during ot+uv", pg_pulldown_o, 1);
        uv_i = 1'b0; ot_i = 1'b0; cool_i = 1'b1;
        tick(3);
        check("R8", "uv outlives ot", fault_o, 5'b01000);
        en_i = 1'b0; tick(3); en_i = 1'b1; tick(3);

        // Over-voltage latch and low-side hysteresis (R4, R5, R11).
        hs_req_i = 1'b1; ls_req_i = 1'b0;
        ov_lo_i = 1'b1; ov_hi_i = 1'b1;
        tick(3);
        check("R4", "ov latched", fault_o, 5'b00100);
        check("R4", "ov pg", pg_pulldown_o, 1);
        check("R4", "ov hs off", hs_gate_o, 0);
        check("R5", "ov ls on above rising", ls_gate_o, 1);
        ov_hi_i = 1'b0;
        tick(3);
        check("R5", "ls held between thresholds", ls_gate_o, 1);
        ov_lo_i = 1'b0;
        tick(3);
        check("R5", "ls off below falling", ls_gate_o, 0);
        ls_req_i = 1'b1;
        tick(1);
        check("R5", "ls request ignored", ls_gate_o, 0);
        ls_req_i = 1'b0;
        ov_lo_i = 1'b1; ov_hi_i = 1'b1;
        tick(3);
        check("R5", "ls on again", ls_gate_o, 1);
        ov_hi_i = 1'b0; ov_lo_i = 1'b0;
        en_i = 1'b0;
        tick(3);
        check("R4", "enable does not clear ov", fault_o, 5'b00100);
        en_i = 1'b1;
        por_i = 1'b1;
        tick(3);
        check("R11", "por clears ov", fault_o, 0);
        check("R11", "por releases pg", pg_pulldown_o, 0);
        por_i = 1'b0;
        tick(3);

        // Overcurrent trip timing with a mid-window high strobe (R2, R10).
        oc_i = 1'b1;
        tick(3);
        pwm_strobe_i = 1'b1;
        n = 0;
        for (int k = 1; k <= OC_CYC + 20; k++) begin
            tick(1);
            if (k == 1) pwm_strobe_i = 1'b0;
            if (k == 50) pwm_strobe_i = 1'b1;
            if (k == 51) pwm_strobe_i = 1'b0;
            if (fault_o[0] && n == 0) n = k;
        end
        check_near("R2", "oc trip edge", n, OC_CYC + 1);
        check("R10", "oc fault code", fault_o, 5'b00001);
        check("R10", "oc pg", pg_pulldown_o, 1);
        check("R9", "oc hs off", hs_gate_o, 0);
        oc_i = 1'b0; en_i = 1'b0;
        tick(3);
        check("R10", "oc cleared by enable", fault_o, 0);
        en_i = 1'b1;
        tick(3);

        // Overcurrent window restart on a clean pulse (R2).
        oc_i = 1'b1;
        tick(3);
        strobe_pulse();
        tick(100);
        oc_i = 1'b0;
        tick(3);
        strobe_pulse();
        oc_i = 1'b1;
        tick(3);
        check("R2", "no trip after restart", fault_o, 0);
        pwm_strobe_i = 1'b1;
        n = 0;
        for (int k = 1; k <= OC_CYC + 20; k++) begin
            tick(1);
            if (k == 1) pwm_strobe_i = 1'b0;
            if (fault_o[0] && n == 0) n = k;
        end
        check_near("R2", "trip edge after restart", n, OC_CYC + 1);
        oc_i = 1'b0; en_i = 1'b0; tick(3); en_i = 1'b1; tick(3);

        // Short-circuit filter: glitch then sustained (R3, R10, R11).
        sc_i = 1'b1;
        tick(10);
        sc_i = 1'b0;
        tick(3);
        check("R3", "short sc pulse ignored", fault_o, 0);
        sc_i = 1'b1;
        n = 0;
        for (int k = 1; k <= SC_CYC + 20; k++) begin
            tick(1);
            if (fault_o[1] && n == 0) n = k;
        end
        check_near("R3", "sc trip edge", n, SC_CYC);
        check("R10", "sc pg", pg_pulldown_o, 1);
        por_i = 1'b1;
        tick(3);
        check("R11", "por clears sc", fault_o, 0);
        por_i = 1'b0; sc_i = 1'b0;
        tick(3);

        done = 1;
        finish_run();
    end
endmodule